// File: doc/BRIEF.md
# External DMA Request Handshake Sequencer

This block controls one DMA channel that serves an external peripheral through a request/acknowledge handshake. Software loads a byte count. From then on, each request the peripheral raises is served by exactly one transfer of the programmed peripheral width. The block strobes the bus side once per transfer, raises the acknowledge to the peripheral during that transfer, and subtracts the transfer width from the remaining count. After every transfer the request input is ignored for a programmable number of cycles, which gives the peripheral time to drop its request line.

The end of the transfer can be signalled in either direction. In the inward direction, the peripheral raises its end-of-transfer line together with the request it wants to be the last one. In the outward direction, the block raises a terminal-count output together with the acknowledge of the final transfer. With the handshake disabled, the channel behaves like an internal peripheral channel. Requests still produce transfers, but the acknowledge and terminal-count outputs stay low and the end-of-transfer input has no effect. Termination is marked by a one-cycle done pulse, after which the channel waits for a new count.

Top module: `xdma_hs_seq`

## Requirements
- R1: After reset, every output is low and requests are not served until a count has been loaded.
- R2: With a nonzero count loaded, a request sampled on a clock edge produces a `xfer_o` pulse of exactly one cycle, starting at that edge. `ack_o` is high in the same cycle when the handshake is enabled.
- R3: `width_i` selects the bytes per transfer: 0 gives 1, 1 gives 2, and 2 or 3 gives 4. The count falls by that amount on each transfer, and a transfer made when the count is at or below the width is the last one.
- R4: After each non-final transfer, requests are ignored for M cycles, where M is `mask_i` and 0 is taken as 1. With the request held high, consecutive transfers are therefore M+2 cycles apart.
- R5: With `end_dir_i`=1 (end driven by the block), `tc_o` is high together with `ack_o` on the final transfer and on no other transfer.
- R6: With `end_dir_i`=0 (end driven by the peripheral), `eot_i` high together with an accepted request makes that transfer the final one. `tc_o` stays low in this mode.
- R7: `eot_i` has no effect when it is not accompanied by an accepted request, and it has no effect at all when `end_dir_i`=1.
- R8: `done_o` pulses for one cycle, in the cycle right after the final transfer. No transfer follows until a new count is loaded.
- R9: With `hs_en_i`=0, `ack_o` and `tc_o` stay low and `eot_i` is ignored. Requests are still served one transfer each, with the mask applied.
- R10: Loading a count of zero leaves the channel idle: no transfers and no done pulse.
- R11: A load while a transfer sequence is in progress restarts the channel with the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | One-cycle strobe that loads `count_i` |
| count_i | input | CNT_W | Byte count to load |
| width_i | input | 2 | Peripheral width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| end_dir_i | input | 1 | 1: block drives terminal count; 0: peripheral drives end-of-transfer |
| hs_en_i | input | 1 | 1: external handshake in use |
| mask_i | input | MASK_W | Request mask length in cycles (0 taken as 1) |
| req_i | input | 1 | Peripheral request |
| eot_i | input | 1 | Peripheral end-of-transfer |
| ack_o | output | 1 | Acknowledge to the peripheral |
| tc_o | output | 1 | Terminal count to the peripheral |
| xfer_o | output | 1 | One-cycle strobe per peripheral-width bus transfer |
| done_o | output | 1 | One-cycle pulse at termination |

## Verification
The assertions watch cycle-level relations on every cycle. Each transfer strobe lasts one cycle. The acknowledge only accompanies a transfer, and the terminal count only accompanies an acknowledge and always leads to done. The outputs stay quiet with the handshake off or the end line set as an input, and done is a single pulse right after a transfer with no transfer behind it. Behaviour that depends on the programmed values can only be shown by the bench's scenarios: how many transfers each width and count give, the spacing set by the mask length, which transfer is final under each end direction, and the effect of a zero or mid-run reload.

// File: rtl/xdma_pkg.sv
`timescale 1ns/1ps
package xdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_XFER  = 3'd2,
    ST_MASK  = 3'd3,
    ST_DONE  = 3'd4
  } hs_state_e;

  localparam int STEP_W = 3;

  // Bytes moved per transfer for a width code.
  function automatic logic [STEP_W-1:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    width_bytes = 3'd1;
      2'd1:    width_bytes = 3'd2;
      default: width_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/xdma_byte_counter.sv
`timescale 1ns/1ps
module xdma_byte_counter #(
  parameter int CNT_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [CNT_W-1:0]           load_val_i,
  input  logic                       dec_i,
  input  logic [xdma_pkg::STEP_W-1:0] step_i,
  input  logic                       force_zero_i,
  output logic [CNT_W-1:0]           cnt_o,
  output logic                       last_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, step_ext;
  logic             cnt_en;

  assign step_ext = CNT_W'(step_i);
  assign last_o   = (cnt_q <= step_ext);
  assign cnt_en   = load_i | dec_i;
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (dec_i) begin
      if (force_zero_i || last_o)
        cnt_d = '0;
      else
        cnt_d = cnt_q - step_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xdma_mask_timer.sv
`timescale 1ns/1ps
module xdma_mask_timer #(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MASK_W-1:0] len_i,
  output logic              expire_o
);
  logic [MASK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign expire_o = (cnt_q == MASK_W'(1));
  assign cnt_en   = start_i | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)
      cnt_d = (len_i == '0) ? MASK_W'(1) : len_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - MASK_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/xdma_hs_fsm.sv
`timescale 1ns/1ps
module xdma_hs_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                load_nz_i,
  input  logic                req_i,
  input  logic                eot_i,
  input  logic                hs_en_i,
  input  logic                end_out_i,
  input  logic                last_i,
  input  logic                mask_expire_i,
  output xdma_pkg::hs_state_e state_o,
  output logic                dec_o,
  output logic                force_zero_o,
  output logic                mask_start_o
);
  import xdma_pkg::*;

  hs_state_e state_q, state_d;
  logic      eot_q, eot_d;
  logic      final_xfer;

  assign final_xfer   = eot_q | last_i;
  assign dec_o        = (state_q == ST_XFER);
  assign force_zero_o = eot_q;
  assign mask_start_o = (state_q == ST_XFER) && !final_xfer && !load_i;
  assign state_o      = state_q;

  always_comb begin
    state_d = state_q;
    eot_d   = eot_q;
    if (load_i) begin
      state_d = load_nz_i ? ST_ARMED : ST_IDLE;
      eot_d   = 1'b0;
    end else begin
      case (state_q)
        ST_ARMED: if (req_i) begin
          state_d = ST_XFER;
          eot_d   = eot_i && hs_en_i && !end_out_i;
        end
        ST_XFER:  state_d = final_xfer ? ST_DONE : ST_MASK;
        ST_MASK:  if (mask_expire_i) state_d = ST_ARMED;
        ST_DONE:  state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
      if (state_q == ST_XFER)
        eot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      eot_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      eot_q   <= eot_d;
    end
  end
endmodule

// File: rtl/xdma_hs_seq.sv
`timescale 1ns/1ps
module xdma_hs_seq #(
  parameter int CNT_W  = 16,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [1:0]        width_i,
  input  logic              end_dir_i,
  input  logic              hs_en_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              req_i,
  input  logic              eot_i,
  output logic              ack_o,
  output logic              tc_o,
  output logic              xfer_o,
  output logic              done_o
);
  import xdma_pkg::*;

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]  rst_sync_q;
  logic                    rst_int_n;
  hs_state_e               state;
  logic                    dec, force_zero, mask_start, mask_expire, last;
  logic [CNT_W-1:0]        cnt;
  logic [STEP_W-1:0]       step;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign step = width_bytes(width_i);

  xdma_hs_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .load_i        (load_i),
    .load_nz_i     (count_i != '0),
    .req_i         (req_i),
    .eot_i         (eot_i),
    .hs_en_i       (hs_en_i),
    .end_out_i     (end_dir_i),
    .last_i        (last),
    .mask_expire_i (mask_expire),
    .state_o       (state),
    .dec_o         (dec),
    .force_zero_o  (force_zero),
    .mask_start_o  (mask_start)
  );

  xdma_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_i       (load_i),
    .load_val_i   (count_i),
    .dec_i        (dec),
    .step_i       (step),
    .force_zero_i (force_zero),
    .cnt_o        (cnt),
    .last_o       (last)
  );

  xdma_mask_timer #(.MASK_W(MASK_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (mask_start),
    .len_i    (mask_i),
    .expire_o (mask_expire)
  );

  assign xfer_o = (state == ST_XFER);
  assign ack_o  = xfer_o && hs_en_i;
  assign tc_o   = ack_o && end_dir_i && last && (cnt != '0);
  assign done_o = (state == ST_DONE);
endmodule

// File: rtl/xdma_hs_seq_chk.sv
`timescale 1ns/1ps
module xdma_hs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic load_i,
  input logic end_dir_i,
  input logic hs_en_i,
  input logic ack_o,
  input logic tc_o,
  input logic xfer_o,
  input logic done_o
);
  assert_xfer_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> !xfer_o);
  assert_ack_in_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> xfer_o);
  assert_tc_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> ack_o);
  assert_tc_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o && !load_i |=> done_o);
  assert_no_tc_inward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !end_dir_i |-> !tc_o);
  assert_quiet_no_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en_i |-> (!ack_o && !tc_o));
  assert_done_after_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(xfer_o));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !load_i |=> !xfer_o);
endmodule

bind xdma_hs_seq xdma_hs_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_i    (load_i),
  .end_dir_i (end_dir_i),
  .hs_en_i   (hs_en_i),
  .ack_o     (ack_o),
  .tc_o      (tc_o),
  .xfer_o    (xfer_o),
  .done_o    (done_o)
);

// File: tb/xdma_hs_seq_test.sv
`timescale 1ns/1ps
module xdma_hs_seq_test;
  localparam int CNT_W  = 16;
  localparam int MASK_W = 4;

  typedef struct packed { logic ack; logic tc; } exp_t;

  logic              clk;
  logic              rst_n;
  logic              load_i;
  logic [CNT_W-1:0]  count_i;
  logic [1:0]        width_i;
  logic              end_dir_i;
  logic              hs_en_i;
  logic [MASK_W-1:0] mask_i;
  logic              req_i;
  logic              eot_i;
  logic              ack_o, tc_o, xfer_o, done_o;

  int   n_chk, n_err, cyc, prev_cyc, exp_gap, n_done, n_xfer;
  bit   have_prev, finished;
  exp_t q[$];
  exp_t e;

  xdma_hs_seq #(.CNT_W(CNT_W), .MASK_W(MASK_W)) uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .count_i(count_i),
    .width_i(width_i), .end_dir_i(end_dir_i), .hs_en_i(hs_en_i),
    .mask_i(mask_i), .req_i(req_i), .eot_i(eot_i),
    .ack_o(ack_o), .tc_o(tc_o), .xfer_o(xfer_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each transfer strobe.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (xfer_o) begin
        n_xfer++;
        if (q.size() == 0)
          chk(1'b0, "R1/R10 unexpected transfer", 1, 0);
        else begin
          e = q.pop_front();
          chk(ack_o == e.ack, "R2/R9 ack_o on transfer", int'(ack_o), int'(e.ack));
          chk(tc_o == e.tc, "R5/R6 tc_o on transfer", int'(tc_o), int'(e.tc));
        end
        if (exp_gap != 0 && have_prev)
          chk(cyc - prev_cyc == exp_gap, "R4 transfer spacing", cyc - prev_cyc, exp_gap);
        prev_cyc  = cyc;
        have_prev = 1'b1;
      end
      if (done_o) begin
        n_done++;
        chk(have_prev && cyc == prev_cyc + 1, "R8 done cycle", cyc, prev_cyc + 1);
      end
    end
  end

  task automatic arm(input int cnt, input int w, input bit dir, input bit hs, input int m, input int gap);
    @(negedge clk);
    count_i   = CNT_W'(cnt);
    width_i   = 2'(w);
    end_dir_i = dir;
    hs_en_i   = hs;
    mask_i    = MASK_W'(m);
    load_i    = 1'b1;
    have_prev = 1'b0;
    exp_gap   = gap;
    @(negedge clk);
    load_i    = 1'b0;
  endtask

  task automatic push(input bit a, input bit t);
    exp_t x;
    x.ack = a;
    x.tc  = t;
    q.push_back(x);
  endtask

  task automatic single_req(input bit with_eot);
    req_i = 1'b1;
    eot_i = with_eot;
    @(negedge clk);
    while (!xfer_o) @(negedge clk);
    req_i = 1'b0;
    eot_i = 1'b0;
  endtask

  task automatic close_scn(input int exp_done, input string tag);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
    chk(n_done == exp_done, "R8 done pulse count", n_done, exp_done);
    q.delete();
    n_done = 0;
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; prev_cyc = 0; exp_gap = 0; n_done = 0; n_xfer = 0;
    have_prev = 0; finished = 0;
    rst_n = 1'b0; load_i = 0; count_i = '0; width_i = 0; end_dir_i = 0;
    hs_en_i = 0; mask_i = '0; req_i = 0; eot_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, then requests with no count loaded
    chk({ack_o, tc_o, xfer_o, done_o} == 4'b0, "R1 outputs after reset",
        int'({ack_o, tc_o, xfer_o, done_o}), 0);
    req_i = 1'b1;
    repeat (8) @(negedge clk);
    req_i = 1'b0;
    chk(n_xfer == 0, "R1 no transfer before load", n_xfer, 0);

    // R2 R3 R4 R5: byte width, block-driven end, mask 2 -> spacing 4
    arm(3, 0, 1, 1, 2, 4);
    push(1, 0); push(1, 0); push(1, 1);
    repeat (3) single_req(0);
    close_scn(1, "R3 width-1 transfers");

    // R3 R4: 2-byte width, count 5 -> 3 transfers; mask 0 taken as 1 -> spacing 3
    arm(5, 1, 1, 1, 0, 3);
    push(1, 0); push(1, 0); push(1, 1);
    repeat (3) single_req(0);
    close_scn(1, "R3 width-2 transfers");

    // R3 R4: 4-byte width, count 8 -> 2 transfers, mask 5 -> spacing 7
    arm(8, 2, 1, 1, 5, 7);
    push(1, 0); push(1, 1);
    repeat (2) single_req(0);
    close_scn(1, "R3 width-4 transfers");

    // R3: code 3 also means 4 bytes, count 4 -> single final transfer
    arm(4, 3, 1, 1, 1, 0);
    push(1, 1);
    single_req(0);
    close_scn(1, "R3 width code 3");

    // R6 R7: peripheral-driven end; lone eot ignored, eot with request ends
    arm(10, 0, 0, 1, 1, 0);
    eot_i = 1'b1;
    repeat (3) @(negedge clk);
    eot_i = 1'b0;
    chk(n_done == 0, "R7 lone eot ignored", n_done, 0);
    push(1, 0); push(1, 0);
    single_req(0);
    single_req(1);
    close_scn(1, "R6 early end by eot");

    // R7: eot ignored when the block drives the end
    arm(2, 0, 1, 1, 1, 0);
    push(1, 0); push(1, 1);
    single_req(1);
    single_req(1);
    close_scn(1, "R7 eot ignored in outward mode");

    // R9: handshake disabled; ack/tc low, eot ignored, spacing still masked
    arm(2, 0, 0, 0, 3, 5);
    push(0, 0); push(0, 0);
    single_req(1);
    single_req(1);
    close_scn(1, "R9 handshake off");

    // R10: zero count leaves channel idle
    n_xfer = 0;
    arm(0, 0, 1, 1, 1, 0);
    req_i = 1'b1;
    repeat (20) @(negedge clk);
    req_i = 1'b0;
    chk(n_xfer == 0, "R10 no transfer on zero load", n_xfer, 0);
    close_scn(0, "R10 zero load");

    // R11: reload mid-run restarts with the new count
    arm(5, 0, 1, 1, 2, 0);
    push(1, 0);
    single_req(0);
    arm(2, 0, 1, 1, 2, 0);
    push(1, 0); push(1, 1);
    repeat (2) single_req(0);
    close_scn(1, "R11 reload restarts");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    finished = 1'b1;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule